// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps one shift register holding the outcomes of the most recent branches, of whatever address. It joins that history with a few low bits of the branch address to select one of 16K two-bit saturating counters. A fetch stage presents a branch address on the lookup port and receives, in the same cycle, a taken or not-taken guess together with the table index that produced it. The fetch stage keeps that index alongside the branch.

When the branch resolves, the execution stage returns the saved index and the real outcome on the training port. The addressed counter moves one step toward the outcome and saturates at its ends. The outcome also enters the history register. A separate load input overwrites the history with a saved value, so that a pipeline flush can put it back.

The counters are stored as words of 32 packed counters. Each training event does a read-modify-write of one word.

Top module: `ghist_dir_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and the history register holds zero, so every lookup predicts not taken and reports an index whose bits [13:6] are zero.
- R2: The lookup index is 14 bits. Bits [13:6] are the history register and bits [5:0] are lookup address bits [7:2]. No other address bit affects the index.
- R3: The guess is taken (1) when the selected counter is 2 or 3, and not taken (0) when it is 0 or 1.
- R4: A training event with outcome taken (1) sets the addressed counter to min(3, value+1).
- R5: A training event with outcome not taken (0) sets the addressed counter to max(0, value-1).
- R6: On each training event the history shifts left by one bit, and the outcome enters at bit 0.
- R7: Training changes only the counter named by the supplied training index, whatever the current history is. All other counters keep their values.
- R8: A history load writes the supplied value into the history. In a cycle with both a load and a training event, the load decides the history and the counter is still trained.
- R9: The lookup is combinational, within the same cycle. A training event or a load takes effect at the next rising clock edge and is visible to lookups from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Branch address to look up |
| lk_taken | output | 1 | Direction guess, 1 = taken |
| lk_index | output | 14 | Table index used for this guess |
| tr_valid | input | 1 | Training event strobe |
| tr_index | input | 14 | Index captured at lookup time |
| tr_taken | input | 1 | Resolved outcome, 1 = taken |
| hist_load | input | 1 | Overwrite the history register |
| hist_load_val | input | 8 | Value for the history overwrite |

## Verification
A lookup result is due in the same cycle as its address. The bench therefore drives `lk_pc` after a falling edge and samples one nanosecond later, before the next rising edge. A training event or history load is held for exactly one rising edge. Its effect on the counter and on `lk_index[13:6]` is due after that edge, so the bench drops the strobes at the following falling edge and only then looks up again. The expected counters and history come from a bench model that applies the saturation and shift rules. Saturation is probed from both ends: wrap-around at 3 or at 0 would give the opposite guess on the next lookup.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_STRONG_NT = 2'd0;
  localparam ctr2_t CTR_WEAK_NT   = 2'd1;
  localparam ctr2_t CTR_STRONG_T  = 2'd3;

  // One saturating training step toward the resolved outcome.
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    if (taken) begin
      nxt = (cur == CTR_STRONG_T) ? cur : cur + 2'd1;
    end else begin
      nxt = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    end
    return nxt;
  endfunction

  // Counters in the upper half predict taken.
  function automatic logic ctr_says_taken(input ctr2_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/ghp_index_gen.sv
module ghp_index_gen #(
  parameter int PC_W     = 32,
  parameter int HIST_W   = 8,
  parameter int PC_SEL_W = 6,
  parameter int PC_LSB   = 2,
  localparam int IDX_W   = HIST_W + PC_SEL_W
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o
);

  always_comb begin
    idx_o = {hist_i, pc_i[PC_LSB +: PC_SEL_W]};
  end

endmodule

// File: rtl/ghp_history.sv
module ghp_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              load_en,
  input  logic [HIST_W-1:0] load_val,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;
  logic              hist_en;

  // Next state: a load wins over the shift.
  always_comb begin
    hist_en = shift_en | load_en;
    if (load_en) begin
      hist_d = load_val;
    end else begin
      hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else if (hist_en) begin
      hist_q <= hist_d;
    end
  end

  assign hist_o = hist_q;

  p_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)})
    else $error("history shift wrong");

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> hist_q == $past(load_val))
    else $error("history load wrong");

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_en) |=> $stable(hist_q))
    else $error("history moved without a cause");

endmodule

// File: rtl/ghp_counter_table.sv
module ghp_counter_table
  import ghp_pkg::*;
#(
  parameter int IDX_W          = 14,
  parameter int SLOTS_PER_WORD = 32,
  localparam int SLOT_W        = $clog2(SLOTS_PER_WORD),
  localparam int WADDR_W       = IDX_W - SLOT_W,
  localparam int WORDS         = 1 << WADDR_W,
  localparam int WORD_W        = 2 * SLOTS_PER_WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  logic [WORD_W-1:0] mem_q [WORDS];

  logic [WADDR_W-1:0] rd_waddr;
  logic [SLOT_W-1:0]  rd_slot;
  logic [WORD_W-1:0]  rd_word;

  logic [WADDR_W-1:0] wr_waddr;
  logic [SLOT_W-1:0]  wr_slot;
  logic [WORD_W-1:0]  wr_word_cur;
  logic [WORD_W-1:0]  wr_word_nxt;
  ctr2_t              wr_old;
  ctr2_t              wr_new;

  // Lookup path: select word, then slot.
  always_comb begin
    rd_waddr = rd_idx[IDX_W-1:SLOT_W];
    rd_slot  = rd_idx[SLOT_W-1:0];
    rd_word  = mem_q[rd_waddr];
    rd_ctr   = rd_word[{rd_slot, 1'b0} +: 2];
  end

  // Training path: read-modify-write of one word.
  always_comb begin
    wr_waddr    = wr_idx[IDX_W-1:SLOT_W];
    wr_slot     = wr_idx[SLOT_W-1:0];
    wr_word_cur = mem_q[wr_waddr];
    wr_old      = wr_word_cur[{wr_slot, 1'b0} +: 2];
    wr_new      = ctr_step(wr_old, wr_taken);
  end

  for (genvar s = 0; s < SLOTS_PER_WORD; s++) begin : g_merge
    assign wr_word_nxt[2*s +: 2] =
      (wr_slot == SLOT_W'(s)) ? wr_new : wr_word_cur[2*s +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) begin
        mem_q[w] <= {SLOTS_PER_WORD{CTR_WEAK_NT}};
      end
    end else if (wr_en) begin
      mem_q[wr_waddr] <= wr_word_nxt;
    end
  end

  // Assertion support: remember the last training event and probe its slot.
  logic             chk_vld_q;
  logic             chk_taken_q;
  logic [IDX_W-1:0] chk_idx_q;
  ctr2_t            chk_old_q;
  logic [WORD_W-1:0] chk_word;
  ctr2_t            chk_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld_q   <= 1'b0;
      chk_taken_q <= 1'b0;
      chk_idx_q   <= '0;
      chk_old_q   <= CTR_WEAK_NT;
    end else begin
      chk_vld_q <= wr_en;
      if (wr_en) begin
        chk_taken_q <= wr_taken;
        chk_idx_q   <= wr_idx;
        chk_old_q   <= wr_old;
      end
    end
  end

  always_comb begin
    chk_word = mem_q[chk_idx_q[IDX_W-1:SLOT_W]];
    chk_now  = chk_word[{chk_idx_q[SLOT_W-1:0], 1'b0} +: 2];
  end

  p_sat_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld_q && chk_taken_q) |->
      chk_now == ((chk_old_q == 2'd3) ? 2'd3 : chk_old_q + 2'd1))
    else $error("taken training wrong");

  p_sat_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld_q && !chk_taken_q) |->
      chk_now == ((chk_old_q == 2'd0) ? 2'd0 : chk_old_q - 2'd1))
    else $error("not-taken training wrong");

endmodule

// File: rtl/ghist_dir_predictor.sv
module ghist_dir_predictor
  import ghp_pkg::*;
#(
  parameter int PC_W           = 32,
  parameter int HIST_W         = 8,
  parameter int PC_SEL_W       = 6,
  parameter int PC_LSB         = 2,
  parameter int SLOTS_PER_WORD = 32,
  localparam int IDX_W         = HIST_W + PC_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              tr_valid,
  input  logic [IDX_W-1:0]  tr_index,
  input  logic              tr_taken,
  input  logic              hist_load,
  input  logic [HIST_W-1:0] hist_load_val
);

  logic [HIST_W-1:0] hist;
  ctr2_t             sel_ctr;

  ghp_history #(
    .HIST_W (HIST_W)
  ) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (tr_valid),
    .shift_bit (tr_taken),
    .load_en   (hist_load),
    .load_val  (hist_load_val),
    .hist_o    (hist)
  );

  ghp_index_gen #(
    .PC_W     (PC_W),
    .HIST_W   (HIST_W),
    .PC_SEL_W (PC_SEL_W),
    .PC_LSB   (PC_LSB)
  ) u_idx (
    .pc_i   (lk_pc),
    .hist_i (hist),
    .idx_o  (lk_index)
  );

  ghp_counter_table #(
    .IDX_W          (IDX_W),
    .SLOTS_PER_WORD (SLOTS_PER_WORD)
  ) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_index),
    .rd_ctr   (sel_ctr),
    .wr_en    (tr_valid),
    .wr_idx   (tr_index),
    .wr_taken (tr_taken)
  );

  always_comb begin
    lk_taken = ctr_says_taken(sel_ctr);
  end

  p_index_hist_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_index[IDX_W-1 -: HIST_W] == hist)
    else $error("index history field mismatch");

endmodule

// File: tb/ghist_dir_predictor_tb.sv
`timescale 1ns/1ps
module ghist_dir_predictor_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_pc;
  logic        lk_taken;
  logic [13:0] lk_index;
  logic        tr_valid;
  logic [13:0] tr_index;
  logic        tr_taken;
  logic        hist_load;
  logic [7:0]  hist_load_val;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int   m_cnt [int];
  logic [7:0] m_hist;

  always #2.5 clk = ~clk;

  ghist_dir_predictor u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_index(lk_index), .tr_valid(tr_valid), .tr_index(tr_index),
    .tr_taken(tr_taken), .hist_load(hist_load), .hist_load_val(hist_load_val)
  );

  function automatic int m_get(input int idx);
    return m_cnt.exists(idx) ? m_cnt[idx] : 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Look up pc and compare against the model (same-cycle result, R9).
  task automatic look(input logic [31:0] pc, input string req);
    int eidx;
    @(negedge clk);
    lk_pc = pc;
    #1;
    eidx = {m_hist, pc[7:2]};
    check(lk_index == 14'(eidx), req, "lookup index", lk_index, eidx);
    check(lk_taken == (m_get(eidx) >= 2), req, "lookup guess", lk_taken,
          int'(m_get(eidx) >= 2));
  endtask

  task automatic train(input logic [13:0] idx, input logic tk,
                       input logic ld, input logic [7:0] lv);
    int c;
    @(negedge clk);
    tr_valid = 1'b1; tr_index = idx; tr_taken = tk;
    hist_load = ld; hist_load_val = lv;
    @(negedge clk);
    tr_valid = 1'b0; hist_load = 1'b0;
    c = m_get(idx);
    m_cnt[idx] = tk ? ((c == 3) ? 3 : c + 1) : ((c == 0) ? 0 : c - 1);
    m_hist = ld ? lv : {m_hist[6:0], tk};
  endtask

  task automatic set_hist(input logic [7:0] v);
    @(negedge clk);
    hist_load = 1'b1; hist_load_val = v;
    @(negedge clk);
    hist_load = 1'b0;
    m_hist = v;
  endtask

  task automatic t_reset;
    look(32'h0000_0000, "R1");
    check(lk_index == 14'h0 && lk_taken == 1'b0, "R1", "reset lookup",
          {lk_index, lk_taken}, 0);
    look(32'h0000_00FC, "R1");
    check(lk_index == 14'h003F, "R2", "pc bits 7:2", lk_index, 14'h003F);
  endtask

  task automatic t_index;
    look(32'hFFFF_FF84, "R2");
    check(lk_index == 14'h0021, "R2", "upper pc ignored", lk_index, 14'h0021);
    look(32'h0000_0087, "R2");
    check(lk_index == 14'h0021, "R2", "low pc ignored", lk_index, 14'h0021);
  endtask

  task automatic t_sat_up;
    train(14'h1A45, 1'b1, 1'b0, 8'h0);
    set_hist(8'h69);
    look(32'h0000_0014, "R3");
    check(lk_taken == 1'b1, "R3", "counter 2 predicts taken", lk_taken, 1);
    for (int i = 0; i < 4; i++) train(14'h1A45, 1'b1, 1'b0, 8'h0);
    train(14'h1A45, 1'b0, 1'b0, 8'h0);
    set_hist(8'h69);
    look(32'h0000_0014, "R4");
    check(lk_taken == 1'b1, "R4", "saturated at 3 then down to 2", lk_taken, 1);
  endtask

  task automatic t_sat_down;
    for (int i = 0; i < 3; i++) train(14'h0ABC, 1'b0, 1'b0, 8'h0);
    train(14'h0ABC, 1'b1, 1'b0, 8'h0);
    set_hist(8'h2A);
    look(32'h0000_00F0, "R5");
    check(lk_taken == 1'b0, "R5", "saturated at 0 then up to 1", lk_taken, 0);
    train(14'h0ABC, 1'b1, 1'b0, 8'h0);
    set_hist(8'h2A);
    look(32'h0000_00F0, "R3");
    check(lk_taken == 1'b1, "R3", "counter 2 taken", lk_taken, 1);
  endtask

  task automatic t_history;
    set_hist(8'h00);
    train(14'h0100, 1'b1, 1'b0, 8'h0);
    train(14'h0101, 1'b0, 1'b0, 8'h0);
    train(14'h0102, 1'b1, 1'b0, 8'h0);
    train(14'h0103, 1'b1, 1'b0, 8'h0);
    look(32'h0, "R6");
    check(lk_index == 14'h02C0, "R6", "history 1011", lk_index, 14'h02C0);
    for (int i = 0; i < 9; i++) train(14'h0200, 1'(i % 2), 1'b0, 8'h0);
    look(32'h0, "R6");
  endtask

  task automatic t_load_priority;
    set_hist(8'h00);
    train(14'h2222, 1'b1, 1'b1, 8'hA5);
    look(32'h0, "R8");
    check(lk_index[13:6] == 8'hA5, "R8", "load beats shift", lk_index[13:6], 8'hA5);
    set_hist(8'h88);
    look(32'h0000_0088, "R8");
    check(lk_taken == 1'b1, "R8", "counter trained under load", lk_taken, 1);
  endtask

  task automatic t_index_independent;
    set_hist(8'h3C);
    look(32'h0000_0010, "R7");
    train(14'h1234, 1'b1, 1'b0, 8'h0);
    train(14'h1234, 1'b1, 1'b0, 8'h0);
    set_hist(8'h3C);
    look(32'h0000_0010, "R7");
    check(lk_taken == 1'b0, "R7", "entry at current history untouched", lk_taken, 0);
    set_hist(8'h48);
    look(32'h0000_00D0, "R7");
    check(lk_taken == 1'b1, "R7", "supplied index trained", lk_taken, 1);
  endtask

  initial begin
    rst_n = 1'b0; lk_pc = '0; tr_valid = 1'b0; tr_index = '0; tr_taken = 1'b0;
    hist_load = 1'b0; hist_load_val = '0; m_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_sat_up();
    t_sat_down();
    t_history();
    t_load_priority();
    t_index_independent();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule